// File: doc/BRIEF.md
# Serial Command Port with Bit Readback

This block is the device side of a three-wire serial control port: a clock line, an active-low select and one shared data line. A host shifts 16-bit command words into it, most significant bit first. The top four bits of each word choose an operation and the lower twelve carry its argument. The block keeps a 128-bit bit-addressable store, which can be cleared as a whole, set one bit at a time and read back one bit at a time. It also holds one configuration value and four converter setpoints in a two-level scheme, and a directly written output-select code.

A bit read turns the shared data line around. The block drives the addressed bit for the following serial clock cycles and then hands the line back to the host. Setpoint and configuration writes land in staging registers. A separate load command moves all five staged values to the live outputs together, so a converter never sees a half-updated set. The serial lines are sampled with the block's own clock, and several words may follow each other without the select line being toggled.

The data line is modelled as an input pin plus an output and output-enable pair. The pad cell combines them outside this block.

Top module: `scp_cmd_port`

## Requirements
- R1: While `cs_n` is low, `dio_in` is sampled at each rising `sclk` edge. Sixteen samples form a word, first bit = bit 15. Bits 15..12 are the opcode and bits 11..0 the data. Words may follow back to back with `cs_n` held low.
- R2: Raising `cs_n` drops any partly received word and forces `dio_oe` low. The next word starts fresh after `cs_n` falls again.
- R3: Opcode 0x1 clears all 128 store bits to 0. Opcode 0x2 sets to 1 the store bit whose index is data bits 6..0.
- R4: Opcode 0x3 selects the store bit given by data bits 6..0, and data bits 11..7 have no effect. After the word, `dio_oe` is high and `dio_out` carries that bit, unchanged, at each of the next 15 rising `sclk` edges.
- R5: `dio_oe` stays high through the 16th `sclk` cycle after a read word and goes low after that cycle's falling edge. Rising edges inside this window are not taken as command bits, and framing resumes with the next cycle.
- R6: Opcode 0x8 writes data bits 11..0 to the configuration staging register, and opcodes 0x9, 0xA, 0xB, 0xC write setpoint staging registers 0..3. `cfg_live` and `dac_live` stay unchanged until opcode 0xF copies all five staged values at once. Setpoint k occupies `dac_live[12k+11:12k]`.
- R7: Opcode 0xD writes data bits 3..0 to `osel` at once, with no load needed.
- R8: Opcode 0x0 and the unassigned opcodes 0x4..0x7 and 0xE change neither the store, the staging or live registers, nor `osel`.
- R9: After reset, `dio_oe`, `dio_out`, `cfg_live`, `dac_live`, `osel` and every store bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low port select |
| dio_in | input | 1 | Data line as seen by the block |
| dio_out | output | 1 | Readback bit driven onto the data line |
| dio_oe | output | 1 | High while the block drives the data line |
| cfg_live | output | 12 | Live configuration value |
| dac_live | output | 48 | Four live 12-bit setpoints, setpoint 0 in the low bits |
| osel | output | 4 | Output-select code |

## Verification
The hardest case to reach from the ports is the turnaround window. The host keeps clocking while the block owns the line, and the block must treat those edges as not belonging to any word. The stimulus reaches it by driving the bits of a full clear-store word onto `dio_in` during the 16 window cycles. It then reads back a bit set earlier, which shows that nothing was decoded and that framing restarted where it should. A second case lifts `cs_n` in the middle of a window and in the middle of a word. A following word that decodes correctly confirms that the counters restarted.

// File: rtl/scp_pkg.sv
package scp_pkg;

  localparam int WORD_W = 16;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 4'h0,
    OP_CLEAR = 4'h1,
    OP_SETB  = 4'h2,
    OP_RDB   = 4'h3,
    OP_CFG   = 4'h8,
    OP_OSEL  = 4'hD,
    OP_LOAD  = 4'hF
  } opcode_e;

  typedef enum logic {
    MODE_RX = 1'b0,
    MODE_TX = 1'b1
  } port_mode_e;

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int                WIDTH   = 1,
  parameter int                STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] stg_d;
    if (g == 0) begin : g_first
      assign stg_d = d;
    end else begin : g_rest
      assign stg_d = stg_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q[g] <= RST_VAL;
      end else begin
        stg_q[g] <= stg_d;
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/scp_frame.sv
module scp_frame
  import scp_pkg::*;
#(
  parameter int TX_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              dio_s,
  input  logic              rd_bit,
  output logic              word_vld,
  output logic [WORD_W-1:0] word,
  output logic              dio_out,
  output logic              dio_oe
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam int TXC_W = $clog2(TX_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
  localparam logic [TXC_W-1:0] TX_END   = TXC_W'(TX_CYCLES);

  logic              sclk_prev_q;
  logic              sclk_rise, sclk_fall;
  port_mode_e        mode_q, mode_d;
  logic [CNT_W-1:0]  bcnt_q, bcnt_d;
  logic [WORD_W-2:0] shreg_q, shreg_d;
  logic [TXC_W-1:0]  txcnt_q, txcnt_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              vld_q, vld_d;
  logic              dout_q, dout_d;
  logic              oe_q, oe_d;
  logic              rd_cmd;

  assign sclk_rise = sclk_s & ~sclk_prev_q;
  assign sclk_fall = ~sclk_s & sclk_prev_q;
  assign rd_cmd    = vld_q && (word_q[WORD_W-1 -: OP_W] == OP_RDB);

  always_comb begin
    mode_d  = mode_q;
    bcnt_d  = bcnt_q;
    shreg_d = shreg_q;
    txcnt_d = txcnt_q;
    word_d  = word_q;
    vld_d   = 1'b0;
    dout_d  = dout_q;
    oe_d    = oe_q;

    if (cs_n_s) begin
      mode_d  = MODE_RX;
      bcnt_d  = '0;
      txcnt_d = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (mode_q)
        MODE_RX: begin
          if (rd_cmd) begin
            mode_d  = MODE_TX;
            txcnt_d = '0;
            dout_d  = rd_bit;
            oe_d    = 1'b1;
          end else if (sclk_rise) begin
            shreg_d = {shreg_q[WORD_W-3:0], dio_s};
            if (bcnt_q == LAST_BIT) begin
              bcnt_d = '0;
              word_d = {shreg_q, dio_s};
              vld_d  = 1'b1;
            end else begin
              bcnt_d = bcnt_q + 1'b1;
            end
          end
        end
        MODE_TX: begin
          if (sclk_rise && (txcnt_q != TX_END)) begin
            txcnt_d = txcnt_q + 1'b1;
          end
          if (sclk_fall && (txcnt_q == TX_END)) begin
            mode_d = MODE_RX;
            bcnt_d = '0;
            oe_d   = 1'b0;
          end
        end
        default: mode_d = MODE_RX;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      mode_q      <= MODE_RX;
      bcnt_q      <= '0;
      shreg_q     <= '0;
      txcnt_q     <= '0;
      word_q      <= '0;
      vld_q       <= 1'b0;
      dout_q      <= 1'b0;
      oe_q        <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_s;
      mode_q      <= mode_d;
      bcnt_q      <= bcnt_d;
      shreg_q     <= shreg_d;
      txcnt_q     <= txcnt_d;
      word_q      <= word_d;
      vld_q       <= vld_d;
      dout_q      <= dout_d;
      oe_q        <= oe_d;
    end
  end

  assign word_vld = vld_q;
  assign word     = word_q;
  assign dio_out  = dout_q;
  assign dio_oe   = oe_q;

endmodule

// File: rtl/scp_regs.sv
module scp_regs
  import scp_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int NUM_DAC  = 4,
  parameter int MEM_BITS = 128,
  parameter int OSEL_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      word_vld,
  input  logic [WORD_W-1:0]         word,
  output logic                      rd_bit,
  output logic [DATA_W-1:0]         cfg_live,
  output logic [NUM_DAC*DATA_W-1:0] dac_live,
  output logic [OSEL_W-1:0]         osel
);

  localparam int ADDR_W = $clog2(MEM_BITS);
  localparam int NREG   = NUM_DAC + 1;

  logic [OP_W-1:0]   op;
  logic [DATA_W-1:0] data;
  logic [ADDR_W-1:0] addr;

  assign op   = word[WORD_W-1 -: OP_W];
  assign data = word[DATA_W-1:0];
  assign addr = data[ADDR_W-1:0];

  // bit store
  logic [MEM_BITS-1:0] mem_q, mem_d;
  logic                mem_en;

  assign mem_en = word_vld && ((op == OP_CLEAR) || (op == OP_SETB));

  always_comb begin
    mem_d = mem_q;
    if (op == OP_CLEAR) begin
      mem_d = '0;
    end else begin
      mem_d[addr] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (mem_en) begin
      mem_q <= mem_d;
    end
  end

  assign rd_bit = mem_q[addr];

  // staged and live values: index 0 is configuration, 1..NUM_DAC setpoints
  logic              load_en;
  logic [DATA_W-1:0] live_q [NREG];

  assign load_en = word_vld && (op == OP_LOAD);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [OP_W-1:0] SEL = OP_W'(int'(OP_CFG) + g);
    logic              stg_en;
    logic [DATA_W-1:0] stg_q;

    assign stg_en = word_vld && (op == SEL);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q <= '0;
      end else if (stg_en) begin
        stg_q <= data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_q[g] <= '0;
      end else if (load_en) begin
        live_q[g] <= stg_q;
      end
    end

    if (g == 0) begin : g_cfg
      assign cfg_live = live_q[g];
    end else begin : g_dac
      assign dac_live[(g-1)*DATA_W +: DATA_W] = live_q[g];
    end
  end

  // output select
  logic              osel_en;
  logic [OSEL_W-1:0] osel_q;

  assign osel_en = word_vld && (op == OP_OSEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osel_q <= '0;
    end else if (osel_en) begin
      osel_q <= data[OSEL_W-1:0];
    end
  end

  assign osel = osel_q;

endmodule

// File: rtl/scp_cmd_port.sv
module scp_cmd_port
  import scp_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int NUM_DAC     = 4,
  parameter int MEM_BITS    = 128,
  parameter int OSEL_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int TX_CYCLES   = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sclk,
  input  logic                      cs_n,
  input  logic                      dio_in,
  output logic                      dio_out,
  output logic                      dio_oe,
  output logic [DATA_W-1:0]         cfg_live,
  output logic [NUM_DAC*DATA_W-1:0] dac_live,
  output logic [OSEL_W-1:0]         osel
);

  logic [2:0]        sync_q;
  logic              cs_n_s, sclk_s, dio_s;
  logic              rd_bit;
  logic              word_vld;
  logic [WORD_W-1:0] word;

  scp_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_n, sclk, dio_in}),
    .q     (sync_q)
  );

  assign cs_n_s = sync_q[2];
  assign sclk_s = sync_q[1];
  assign dio_s  = sync_q[0];

  scp_frame #(
    .TX_CYCLES (TX_CYCLES)
  ) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_s   (sclk_s),
    .cs_n_s   (cs_n_s),
    .dio_s    (dio_s),
    .rd_bit   (rd_bit),
    .word_vld (word_vld),
    .word     (word),
    .dio_out  (dio_out),
    .dio_oe   (dio_oe)
  );

  scp_regs #(
    .DATA_W   (DATA_W),
    .NUM_DAC  (NUM_DAC),
    .MEM_BITS (MEM_BITS),
    .OSEL_W   (OSEL_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_vld (word_vld),
    .word     (word),
    .rd_bit   (rd_bit),
    .cfg_live (cfg_live),
    .dac_live (dac_live),
    .osel     (osel)
  );

endmodule

// File: rtl/scp_port_chk.sv
module scp_port_chk #(
  parameter int DATA_W  = 12,
  parameter int NUM_DAC = 4,
  parameter int OSEL_W  = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cs_n_s,
  input logic                      sclk_s,
  input logic                      word_vld,
  input logic [3:0]                word_op,
  input logic                      dio_out,
  input logic                      dio_oe,
  input logic [DATA_W-1:0]         cfg_live,
  input logic [NUM_DAC*DATA_W-1:0] dac_live,
  input logic [OSEL_W-1:0]         osel
);

  // R2: an inactive select releases the line
  p_release_on_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> !dio_oe);

  // R4: the driven bit does not change while the line stays driven
  p_dout_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dio_oe && $past(dio_oe)) |-> $stable(dio_out));

  // R4: driving starts only right after a decoded read word
  p_drive_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dio_oe) |-> ($past(word_vld) && ($past(word_op) == 4'h3)));

  // R5: release happens with the serial clock low or the select inactive
  p_release_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dio_oe) |-> ($past(cs_n_s) || !$past(sclk_s)));

  // R6: live values move only on a load word
  p_live_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_vld && (word_op == 4'hF)) |=> ($stable(cfg_live) && $stable(dac_live)));

  // R7: the select code moves only on its own opcode
  p_osel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_vld && (word_op == 4'hD)) |=> $stable(osel));

endmodule

bind scp_cmd_port scp_port_chk #(
  .DATA_W  (DATA_W),
  .NUM_DAC (NUM_DAC),
  .OSEL_W  (OSEL_W)
) u_port_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n_s   (cs_n_s),
  .sclk_s   (sclk_s),
  .word_vld (word_vld),
  .word_op  (word[15:12]),
  .dio_out  (dio_out),
  .dio_oe   (dio_oe),
  .cfg_live (cfg_live),
  .dac_live (dac_live),
  .osel     (osel)
);

// File: tb/tb_scp_cmd_port.sv
module tb_scp_cmd_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        dio_in = 1'b0;
  logic        dio_out, dio_oe;
  logic [11:0] cfg_live;
  logic [47:0] dac_live;
  logic [3:0]  osel;

  int total = 0;
  int bad   = 0;

  scp_cmd_port dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .dio_in   (dio_in),
    .dio_out  (dio_out),
    .dio_oe   (dio_oe),
    .cfg_live (cfg_live),
    .dac_live (dac_live),
    .osel     (osel)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sclk = 1'b0;
    dio_in = b;
    half();
    sclk = 1'b1;
    half();
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
  endtask

  // read command, then walk the 16-cycle window driving 'noise' on dio_in
  task automatic read_chk(input logic [15:0] cmd, input logic exp, input string tag,
                          input logic [15:0] noise);
    send_word(cmd);
    for (int k = 1; k <= 16; k++) begin
      sclk = 1'b0;
      dio_in = noise[16-k];
      half();
      if (k <= 15) begin
        check({tag, " R4 oe"}, dio_oe, 1'b1);
        check({tag, " R4 bit"}, dio_out, exp);
      end else begin
        check({tag, " R5 oe before last fall"}, dio_oe, 1'b1);
      end
      sclk = 1'b1;
      half();
    end
    sclk = 1'b0;
    half();
    check({tag, " R5 released"}, dio_oe, 1'b0);
  endtask

  task automatic t_reset();
    check("R9 dio_oe", dio_oe, 1'b0);
    check("R9 dio_out", dio_out, 1'b0);
    check("R9 cfg_live", cfg_live, 12'h0);
    check("R9 dac_live", dac_live, 48'h0);
    check("R9 osel", osel, 4'h0);
    cs_n = 1'b0;
    read_chk(16'h3040, 1'b0, "R9 store bit 64", 16'h0);
    cs_n = 1'b1;
    half();
  endtask

  task automatic t_bits();
    cs_n = 1'b0;
    send_word(16'h2005);
    send_word(16'h207F);
    send_word(16'h2000);
    read_chk(16'h3005, 1'b1, "R3 bit5", 16'h0);
    read_chk(16'h3006, 1'b0, "R3 bit6", 16'h0);
    read_chk(16'h307F, 1'b1, "R1 bit127 back-to-back", 16'h0);
    read_chk(16'h3000, 1'b1, "R3 bit0", 16'h0);
    read_chk(16'h3F85, 1'b1, "R4 upper bits ignored set", 16'h0);
    read_chk(16'h3F86, 1'b0, "R4 upper bits ignored clear", 16'h0);
    cs_n = 1'b1;
    half();
  endtask

  task automatic t_clear();
    cs_n = 1'b0;
    send_word(16'h1000);
    read_chk(16'h3005, 1'b0, "R3 cleared bit5", 16'h0);
    read_chk(16'h307F, 1'b0, "R3 cleared bit127", 16'h0);
    cs_n = 1'b1;
    half();
  endtask

  task automatic t_window();
    cs_n = 1'b0;
    send_word(16'h2009);
    // a clear-store word clocked in during the window must be ignored
    read_chk(16'h3009, 1'b1, "R5 window noise", 16'h1000);
    read_chk(16'h3009, 1'b1, "R5 no decode in window", 16'h0);
    cs_n = 1'b1;
    half();
  endtask

  task automatic t_regs();
    cs_n = 1'b0;
    send_word(16'h8ABC);
    send_word(16'h9111);
    send_word(16'hA222);
    send_word(16'hB333);
    send_word(16'hC444);
    half();
    check("R6 cfg before load", cfg_live, 12'h0);
    check("R6 dac before load", dac_live, 48'h0);
    send_word(16'hF000);
    half();
    check("R6 cfg after load", cfg_live, 12'hABC);
    check("R6 dac after load", dac_live, 48'h444333222111);
    send_word(16'h8555);
    send_word(16'h9666);
    half();
    check("R6 cfg holds without load", cfg_live, 12'hABC);
    check("R6 dac holds without load", dac_live, 48'h444333222111);
    send_word(16'hF000);
    half();
    check("R6 cfg second load", cfg_live, 12'h555);
    check("R6 dac second load", dac_live, 48'h444333222666);
    cs_n = 1'b1;
    half();
  endtask

  task automatic t_osel();
    cs_n = 1'b0;
    send_word(16'hD00B);
    half();
    check("R7 osel B", osel, 4'hB);
    send_word(16'hD0F6);
    half();
    check("R7 osel low bits", osel, 4'h6);
    cs_n = 1'b1;
    half();
  endtask

  task automatic t_ignored();
    cs_n = 1'b0;
    send_word(16'h8777);
    send_word(16'h5FFF);
    send_word(16'h4FFF);
    send_word(16'h7F88);
    send_word(16'hE123);
    send_word(16'h0FFF);
    half();
    check("R8 osel kept", osel, 4'h6);
    check("R8 cfg kept", cfg_live, 12'h555);
    check("R8 dac kept", dac_live, 48'h444333222666);
    read_chk(16'h3009, 1'b1, "R8 store kept bit9", 16'h0);
    read_chk(16'h3008, 1'b0, "R8 store kept bit8", 16'h0);
    send_word(16'hF000);
    half();
    check("R8 staged value kept", cfg_live, 12'h777);
    cs_n = 1'b1;
    half();
  endtask

  task automatic t_cs();
    // partial word then deselect
    cs_n = 1'b0;
    for (int i = 15; i >= 8; i--) send_bit(16'h8FFF >> i);
    cs_n = 1'b1;
    half();
    half();
    check("R2 idle after abort", dio_oe, 1'b0);
    cs_n = 1'b0;
    send_word(16'hD007);
    half();
    check("R2 fresh word after abort", osel, 4'h7);
    check("R2 partial word dropped", cfg_live, 12'h777);
    // deselect in the middle of a readback window
    send_word(16'h3009);
    send_bit(1'b0);
    send_bit(1'b0);
    check("R2 driving in window", dio_oe, 1'b1);
    cs_n = 1'b1;
    half();
    check("R2 released by deselect", dio_oe, 1'b0);
    half();
    cs_n = 1'b0;
    send_word(16'hD003);
    half();
    check("R2 framing after window abort", osel, 4'h3);
    cs_n = 1'b1;
    half();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_bits();
    t_clear();
    t_window();
    t_regs();
    t_osel();
    t_ignored();
    t_cs();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule